// File: doc/BRIEF.md
# Daisy-Chain Command Frame Builder

This block sits on the host side of a serial link that feeds a string of chained devices. Software, or a sequencer, hands it one request at a time on a small command port. It turns each request into the exact byte sequence that a downstream SPI shifter sends to the chain. There are four kinds of request:

- open a registered (synchronous) forward path through the current device;
- open a direct (asynchronous) forward path;
- close the chain;
- write a block of 32-bit words to an address inside a device.

Bytes leave through a byte stream with valid/ready flow control. Payload bytes come from a separate byte stream with the same flow control. The block pulls payload bytes from that stream only while it is emitting the body of a write.

A write emits three leading bytes, which go out as they are:

- a header byte that carries the word count;
- the high byte of the address;
- the low byte of the address.

The body follows, and every payload byte in the body leaves with its bit order mirrored. A write whose length cannot fit in one frame is refused. A refused write produces no bytes and raises a one-cycle error pulse, and it does not hold up the command port.

Top module: `chain_frame_builder`

## Requirements
- R1: A command with `cmd_op` = 0 (close chain) emits exactly one byte, 0x04.
- R2: `cmd_op` = 1 (registered forward) emits exactly one byte, 0x06; `cmd_op` = 2 (direct forward) emits exactly one byte, 0x05.
- R3: `cmd_op` = 3 (write) emits as its first byte 0xE0 OR (words − 1), where words = `cmd_len` / 4 with the remainder discarded.
- R4: The header of a write is followed by `cmd_addr[15:8]` and then `cmd_addr[7:0]`, both unmodified.
- R5: After the address, a write takes exactly 4 × words bytes from the payload stream. It emits each one with bit i of the input on bit 7−i of the output, in arrival order.
- R6: A write with `cmd_len` < 4 or `cmd_len` > 128 is accepted and emits no bytes. It takes no payload bytes and raises `err` for exactly the one cycle that follows its acceptance.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values into the next cycle.
- R8: `cmd_ready` is high exactly when no byte of an earlier command is still pending. A new command is taken only after the last byte of the previous one has been accepted downstream.
- R9: After reset, `out_valid` = 0, `err` = 0, `pay_ready` = 0 and `cmd_ready` = 1.
- R10: The first byte of an accepted, legal command is presented on `out_valid` in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command request present |
| cmd_ready | output | 1 | Builder idle; command taken when both are high |
| cmd_op | input | 2 | 0 close, 1 registered forward, 2 direct forward, 3 write |
| cmd_addr | input | 16 | Target address of a write |
| cmd_len | input | 8 | Write length in bytes |
| pay_valid | input | 1 | Payload byte present |
| pay_ready | output | 1 | Payload byte taken when both are high |
| pay_data | input | 8 | Payload byte, natural bit order |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte when both are high |
| out_data | output | 8 | Encoded output byte |
| err | output | 1 | One-cycle pulse for a refused write |

## Verification
The timing of each result follows from the handshakes:
- The first byte of a legal command, and the `err` pulse of a refused one, appear one cycle after the command handshake.
- Each later byte appears in the cycle after the previous byte's output handshake, or in the same cycle for a payload byte that is already waiting.
- `cmd_ready` returns in the cycle after the final byte is taken.

The bench samples every output at the falling clock edge, after the rising edge that made it due. It compares output bytes in handshake order against a queue filled with expected bytes when each request is issued. The `err` pulse and the first-byte presence are checked at the first falling edge after the command handshake. Back-pressure patterns on `out_ready` check that stalled bytes hold and that no byte is skipped.

// File: rtl/chain_frame_pkg.sv
package chain_frame_pkg;

  typedef enum logic [1:0] {
    CMD_CLOSE = 2'd0,
    CMD_FWD_REG = 2'd1,
    CMD_FWD_DIR = 2'd2,
    CMD_WRITE = 2'd3
  } cmd_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_BODY
  } seq_state_e;

  localparam logic [7:0] BYTE_CLOSE   = 8'h04;
  localparam logic [7:0] BYTE_FWD_REG = 8'h06;
  localparam logic [7:0] BYTE_FWD_DIR = 8'h05;
  localparam logic [7:0] HDR_BASE     = 8'hE0;
  localparam int unsigned ADDR_W      = 16;
  localparam int unsigned BYTE_W      = 8;

endpackage

// File: rtl/frame_reset_sync.sv
module frame_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/frame_len_check.sv
module frame_len_check
  import chain_frame_pkg::*;
#(
  parameter int unsigned LEN_W     = 8,
  parameter int unsigned MIN_BYTES = 4,
  parameter int unsigned MAX_BYTES = 128
) (
  input  logic [LEN_W-1:0]  len,
  output logic              legal,
  output logic [BYTE_W-1:0] hdr_byte,
  output logic [LEN_W-1:0]  body_bytes
);
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned SHIFT      = $clog2(WORD_BYTES);
  localparam int unsigned CNT_W      = $clog2(MAX_BYTES / WORD_BYTES);

  logic [LEN_W-1:0] words;
  logic [LEN_W-1:0] words_m1;

  always_comb begin
    words      = len >> SHIFT;
    words_m1   = words - 1'b1;
    legal      = (len >= LEN_W'(MIN_BYTES)) && (len <= LEN_W'(MAX_BYTES));
    body_bytes = words << SHIFT;
    hdr_byte   = HDR_BASE | BYTE_W'(words_m1[CNT_W-1:0]);
  end
endmodule

// File: rtl/frame_bitrev.sv
module frame_bitrev #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < W; g++) begin : g_mirror
    assign dout[g] = din[W-1-g];
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import chain_frame_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              len_legal,
  input  logic [BYTE_W-1:0] hdr_byte,
  input  logic [LEN_W-1:0]  body_bytes,
  input  logic              pay_valid,
  input  logic [BYTE_W-1:0] pay_rev,
  input  logic              out_ready,
  output logic              cmd_ready,
  output logic              pay_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              err
);
  seq_state_e        state_q, state_d;
  logic [BYTE_W-1:0] lead_q, lead_d;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic              err_q, err_d;
  logic              cmd_fire, out_fire, body_beat;
  logic              lead_en, addr_en, cnt_en;
  logic              is_write;

  always_comb begin
    cmd_ready = live && (state_q == ST_IDLE);
    cmd_fire  = cmd_valid && cmd_ready;
    is_write  = (cmd_op == CMD_WRITE);
    out_valid = (state_q == ST_LEAD) || (state_q == ST_ADDR_HI) ||
                (state_q == ST_ADDR_LO) || ((state_q == ST_BODY) && pay_valid);
    out_fire  = out_valid && out_ready;
    pay_ready = (state_q == ST_BODY) && out_ready;
    body_beat = (state_q == ST_BODY) && pay_valid && out_ready;
    unique case (state_q)
      ST_LEAD:    out_data = lead_q;
      ST_ADDR_HI: out_data = addr_q[ADDR_W-1 -: BYTE_W];
      ST_ADDR_LO: out_data = addr_q[BYTE_W-1:0];
      ST_BODY:    out_data = pay_rev;
      default:    out_data = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    err_d   = 1'b0;
    lead_d  = lead_q;
    lead_en = 1'b0;
    addr_en = 1'b0;
    cnt_en  = 1'b0;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_fire) begin
          unique case (cmd_op)
            CMD_CLOSE:   lead_d = BYTE_CLOSE;
            CMD_FWD_REG: lead_d = BYTE_FWD_REG;
            CMD_FWD_DIR: lead_d = BYTE_FWD_DIR;
            default:     lead_d = hdr_byte;
          endcase
          if (is_write && !len_legal) begin
            err_d = 1'b1;
          end else begin
            lead_en = 1'b1;
            addr_en = is_write;
            cnt_en  = is_write;
            cnt_d   = body_bytes;
            state_d = ST_LEAD;
          end
        end
      end
      ST_LEAD: begin
        if (out_fire) state_d = (cnt_q != '0) ? ST_ADDR_HI : ST_IDLE;
      end
      ST_ADDR_HI: begin
        if (out_fire) state_d = ST_ADDR_LO;
      end
      ST_ADDR_LO: begin
        if (out_fire) state_d = ST_BODY;
      end
      ST_BODY: begin
        if (body_beat) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
          if (cnt_q == LEN_W'(1)) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      lead_q  <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (lead_en) lead_q <= lead_d;
      if (addr_en) addr_q <= cmd_addr;
      if (lead_en) cnt_q  <= is_write ? cnt_d : '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign err = err_q;
endmodule

// File: rtl/chain_frame_builder.sv
module chain_frame_builder
  import chain_frame_pkg::*;
#(
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned MIN_BYTES  = 4,
  parameter int unsigned MAX_BYTES  = 128,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [15:0]       cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [7:0]        pay_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              err
);
  logic              srst_n;
  logic              len_legal;
  logic [BYTE_W-1:0] hdr_byte;
  logic [LEN_W-1:0]  body_bytes;
  logic [BYTE_W-1:0] pay_rev;

  frame_reset_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  frame_len_check #(
    .LEN_W(LEN_W), .MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES)
  ) i_len (
    .len(cmd_len), .legal(len_legal), .hdr_byte(hdr_byte), .body_bytes(body_bytes)
  );

  frame_bitrev #(.W(BYTE_W)) i_rev (.din(pay_data), .dout(pay_rev));

  frame_seq #(.LEN_W(LEN_W)) i_seq (
    .clk(clk), .rst_n(srst_n), .live(srst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .len_legal(len_legal), .hdr_byte(hdr_byte), .body_bytes(body_bytes),
    .pay_valid(pay_valid), .pay_rev(pay_rev), .out_ready(out_ready),
    .cmd_ready(cmd_ready), .pay_ready(pay_ready), .out_valid(out_valid),
    .out_data(out_data), .err(err)
  );
endmodule

// File: rtl/chain_frame_chk.sv
module chain_frame_chk #(
  parameter int unsigned LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic [15:0]      cmd_addr,
  input logic [LEN_W-1:0] cmd_len,
  input logic             pay_valid,
  input logic             pay_ready,
  input logic [7:0]       pay_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             err
);
  // R1
  close_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd0) |=> (out_valid && out_data == 8'h04));

  // R2
  fwd_reg_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd1) |=> (out_valid && out_data == 8'h06));

  // R2
  fwd_dir_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd2) |=> (out_valid && out_data == 8'h05));

  // R6
  err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(cmd_valid && cmd_ready && cmd_op == 2'd3));

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!out_valid && !pay_ready));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cmd_ready);

  // R5
  body_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && pay_ready) |-> (out_valid && out_ready));
endmodule

bind chain_frame_builder chain_frame_chk #(.LEN_W(LEN_W)) i_chk (.*);

// File: tb/test_chain_frame_builder.sv
module test_chain_frame_builder;
  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic       cmd_ready;
  logic [1:0] cmd_op;
  logic [15:0] cmd_addr;
  logic [7:0] cmd_len;
  logic       pay_valid;
  logic       pay_ready;
  logic [7:0] pay_data;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_data;
  logic       err;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;
  bit stall_on = 0;
  int cyc      = 0;

  logic [7:0] exp_q[$];
  logic [7:0] pay_q[$];

  chain_frame_builder i_chain_frame_builder (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .err(err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] mirror(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  logic       held_v = 1'b0;
  logic [7:0] held_d = 8'h00;
  always begin
    @(negedge clk);
    cyc++;
    out_ready = stall_on ? ((cyc % 3) != 1) : 1'b1;
    pay_valid = (pay_q.size() != 0);
    pay_data  = (pay_q.size() != 0) ? pay_q[0] : 8'h00;
    #1;
    if (held_v) check(out_valid && out_data == held_d, "R7 stall hold", int'(out_data), int'(held_d));
    held_v = out_valid && !out_ready;
    held_d = out_data;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R6/R8 unexpected byte", int'(out_data), -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(out_data == e, "R1-R5 byte", int'(out_data), int'(e));
      end
    end
    if (pay_valid && pay_ready) void'(pay_q.pop_front());
  end

  task automatic send(input logic [1:0] op, input logic [15:0] addr, input logic [7:0] len);
    bit reject;
    int words;
    reject = (op == 2'd3) && ((len < 8'd4) || (len > 8'd128));
    words  = len / 4;
    case (op)
      2'd0: exp_q.push_back(8'h04);
      2'd1: exp_q.push_back(8'h06);
      2'd2: exp_q.push_back(8'h05);
      default: if (!reject) begin
        exp_q.push_back(8'hE0 | 8'(words - 1));
        exp_q.push_back(addr[15:8]);
        exp_q.push_back(addr[7:0]);
        for (int i = 0; i < words * 4; i++) begin
          logic [7:0] p;
          p = 8'(i * 37 + addr[7:0] + 3);
          pay_q.push_back(p);
          exp_q.push_back(mirror(p));
        end
      end
    endcase
    @(negedge clk);
    #2;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_len = len;
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #3;
    end
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    #3;
    check(err == reject, "R6 err pulse", int'(err), int'(reject));
    if (!reject) begin
      check(out_valid == 1'b1, "R10 first byte due", int'(out_valid), 1);
      check(cmd_ready == 1'b0, "R8 busy", int'(cmd_ready), 0);
    end else begin
      check(cmd_ready == 1'b1, "R6 no stall", int'(cmd_ready), 1);
      check(pay_ready == 1'b0, "R6 no payload taken", int'(pay_ready), 0);
      @(negedge clk);
      #3;
      check(err == 1'b0, "R6 single pulse", int'(err), 0);
    end
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while ((exp_q.size() != 0) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    #3;
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    check(pay_q.size() == 0, req, pay_q.size(), 0);
    check(cmd_ready == 1'b1 && !out_valid, "R8 idle after last byte", int'(cmd_ready), 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_addr = '0; cmd_len = '0;
    repeat (4) @(negedge clk);
    #3;
    check(!out_valid && !err && !pay_ready, "R9 reset outputs", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    check(cmd_ready == 1'b1, "R9 ready after reset", int'(cmd_ready), 1);

    send(2'd0, 16'h0000, 8'd0);       drain("R1 close");
    send(2'd1, 16'h0000, 8'd0);       drain("R2 registered forward");
    send(2'd2, 16'h0000, 8'd0);       drain("R2 direct forward");
    send(2'd3, 16'h1234, 8'd4);       drain("R3 R4 R5 one word");
    send(2'd3, 16'hBEEF, 8'd128);     drain("R3 R5 max length");
    send(2'd3, 16'h00A5, 8'd7);       drain("R5 remainder dropped");
    send(2'd3, 16'h4321, 8'd3);       drain("R6 short reject");
    send(2'd3, 16'h4321, 8'd129);     drain("R6 long reject");
    send(2'd3, 16'h4321, 8'd0);       drain("R6 zero reject");
    stall_on = 1;
    send(2'd3, 16'hC0DE, 8'd20);      drain("R7 stalled write");
    send(2'd0, 16'h0000, 8'd0);
    send(2'd3, 16'h5A5A, 8'd8);
    send(2'd2, 16'h0000, 8'd0);
    send(2'd3, 16'h0101, 8'd200);
    send(2'd1, 16'h0000, 8'd0);       drain("R8 back to back");
    stall_on = 0;
    finish_run();
  end
endmodule